// File: doc/BRIEF.md
# CCM Authenticated Encryption Sequencer

This block produces CCM ciphertext and a truncated authentication tag by driving one external 128-bit block-cipher engine over and over. The key, the nonce, the associated data and the payload are shifted in as bytes while a load strobe is high. A one-cycle go pulse then starts a job. The sequencer builds the first authentication block and the length-prefixed associated-data blocks. It runs the CBC-MAC chain through the engine, then encrypts two counter blocks. Finally it offers the payload ciphertext and the tag one byte at a time, and a consumer takes each byte with a pop strobe.

The engine sits behind a start/done port. The sequencer presents the key and one input block for a single cycle with `eng_start`, and then waits for a one-cycle `eng_done` that carries the result. The engine can take any number of cycles. A three-bit step index picks the block that is routed to the engine on each call, so one engine serves the authentication pass and the counter-mode pass in turn. The supported setup uses a 16-byte key, an 8-byte nonce, 16 bytes of associated data, a 16-byte payload and a 6-byte tag.

Top module: `ccm_seq`

## Requirements
- R1: After reset, `out_vld` and `eng_start` are low.
- R2: While the block is idle, each cycle with `ld_stb` high shifts one byte into each of the key, associated-data and payload registers, with the first byte ending up as the most significant. Sixteen such beats fill these registers. The nonce register keeps the eight most recently loaded nonce bytes. `eng_key` shows the loaded key.
- R3: The first engine call of a job uses the block B0. B0 is the flags byte 0x56, then the nonce, then the payload length (16) as a 7-byte big-endian value.
- R4: The second engine call uses the first result XORed with {0x0010, associated data bytes 0..13}. The third call uses the second result XORed with {associated data bytes 14..15, fourteen zero bytes}.
- R5: The fourth call uses the third result XORed with the payload block. Its result is the final MAC value.
- R6: The fifth call uses counter block 1 and the sixth uses counter block 0. Counter block i is the flags byte 0x06, then the nonce, then i as a 7-byte big-endian value.
- R7: A job makes exactly six engine calls. Each `eng_start` lasts one cycle, and no new start is issued before the previous call's `eng_done`.
- R8: After the sixth result, `out_vld` rises. The first 16 bytes offered are the payload XORed with the encryption of counter block 1, most significant byte first.
- R9: The next 6 bytes are the top 48 bits of the final MAC value XORed with the top 48 bits of the encryption of counter block 0.
- R10: While `out_vld` is high and `pop` is low, the offered byte holds. A `pop` while no byte is offered has no effect.
- R11: `ld_stb` and `go` are ignored from the start of a job until its last byte is popped. No engine call starts while output bytes are still offered.
- R12: Once the 22nd byte has been popped, `out_vld` is low and a new job can be loaded and started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_stb | input | 1 | Load beat strobe |
| key_byte | input | 8 | Key byte for this beat |
| nonce_byte | input | 8 | Nonce byte for this beat |
| aad_byte | input | 8 | Associated-data byte for this beat |
| pt_byte | input | 8 | Payload byte for this beat |
| go | input | 1 | Starts a job when idle |
| pop | input | 1 | Takes the offered output byte |
| out_byte | output | 8 | Offered ciphertext or tag byte |
| out_vld | output | 1 | An output byte is offered |
| eng_start | output | 1 | One-cycle engine call request |
| eng_key | output | 128 | Key for the engine |
| eng_block | output | 128 | Engine input block |
| eng_done | input | 1 | One-cycle engine completion |
| eng_result | input | 128 | Engine output block |

## Verification
The hardest case to reach from the ports is stray control during a job: load beats, a go pulse and a pop that arrive while a call is pending. The next hardest is an engine that answers on the very next cycle, so the call pipeline runs with no slack. The bench models the engine with a latency it sets for each job, from one cycle up to tens of cycles. On chosen jobs it injects junk load beats, go and pop while the job runs. It uses a keyed nonlinear stand-in cipher, so that any mistake in chaining, ordering or formatting changes both the logged engine inputs and the output bytes.

// File: rtl/ccm_seq_pkg.sv
// Shared sizes, derived constants and types for the CCM sequencer.
// Assumes the fixed job shape: 16-byte associated data and payload.
package ccm_seq_pkg;
    localparam int BYTE_W    = 8;
    localparam int BLK_W     = 128;
    localparam int BLK_B     = BLK_W / BYTE_W;
    localparam int NONCE_B   = 8;
    localparam int TAG_B     = 6;
    localparam int AAD_B     = 16;
    localparam int PT_B      = 16;
    localparam int NONCE_W   = NONCE_B * BYTE_W;
    localparam int Q_B       = BLK_B - 1 - NONCE_B;
    localparam int LEN_W     = Q_B * BYTE_W;
    localparam int TAG_W     = TAG_B * BYTE_W;
    localparam int ALEN_W    = 16;
    localparam int OUT_B     = PT_B + TAG_B;
    localparam int OUT_W     = OUT_B * BYTE_W;
    localparam int CNT_W     = $clog2(OUT_B + 1);
    localparam logic [7:0] B0_FLAGS  = 8'(64 + 8 * ((TAG_B - 2) / 2) + (Q_B - 1));
    localparam logic [7:0] CTR_FLAGS = 8'(Q_B - 1);

    // Engine call order within one job; the step index walks this list.
    typedef enum logic [2:0] {
        STEP_B0   = 3'd0,
        STEP_A1   = 3'd1,
        STEP_A2   = 3'd2,
        STEP_PT   = 3'd3,
        STEP_CTR1 = 3'd4,
        STEP_CTR0 = 3'd5
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRAIN = 2'd3
    } state_e;
endpackage

// File: rtl/ccm_loader.sv
// Byte-serial capture of key, nonce, associated data and payload.
// Assumes the caller gates shift_en so that loads happen only while idle.
module ccm_loader
    import ccm_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic [BYTE_W-1:0]  key_byte,
    input  logic [BYTE_W-1:0]  nonce_byte,
    input  logic [BYTE_W-1:0]  aad_byte,
    input  logic [BYTE_W-1:0]  pt_byte,
    output logic [BLK_W-1:0]   key_q,
    output logic [NONCE_W-1:0] nonce_q,
    output logic [BLK_W-1:0]   aad_q,
    output logic [BLK_W-1:0]   pt_q
);
    // Shift each register left by one byte per load beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            nonce_q <= '0;
            aad_q   <= '0;
            pt_q    <= '0;
        end else if (shift_en) begin
            key_q   <= {key_q[BLK_W-BYTE_W-1:0], key_byte};
            nonce_q <= {nonce_q[NONCE_W-BYTE_W-1:0], nonce_byte};
            aad_q   <= {aad_q[BLK_W-BYTE_W-1:0], aad_byte};
            pt_q    <= {pt_q[BLK_W-BYTE_W-1:0], pt_byte};
        end
    end
endmodule

// File: rtl/ccm_blockmux.sv
// Builds the engine input block for the current step: the formatted
// authentication blocks chained with the running MAC, or counter blocks.
// Assumes 16 bytes of associated data, split 14 + 2 by the length prefix.
module ccm_blockmux
    import ccm_seq_pkg::*;
(
    input  step_e              step,
    input  logic [BLK_W-1:0]   chain,
    input  logic [NONCE_W-1:0] nonce,
    input  logic [BLK_W-1:0]   aad,
    input  logic [BLK_W-1:0]   pt,
    output logic [BLK_W-1:0]   blk
);
    // Select and format the block routed to the engine.
    always_comb begin
        case (step)
            STEP_B0:   blk = {B0_FLAGS, nonce, LEN_W'(PT_B)};
            STEP_A1:   blk = chain ^ {ALEN_W'(AAD_B), aad[BLK_W-1:ALEN_W]};
            STEP_A2:   blk = chain ^ {aad[ALEN_W-1:0], {(BLK_W-ALEN_W){1'b0}}};
            STEP_PT:   blk = chain ^ pt;
            STEP_CTR1: blk = {CTR_FLAGS, nonce, LEN_W'(1)};
            default:   blk = {CTR_FLAGS, nonce, LEN_W'(0)};
        endcase
    end
endmodule

// File: rtl/ccm_outq.sv
// Output byte queue: loaded with ciphertext and tag in one cycle, then
// offers one byte at a time, most significant first, advancing on pop.
// Assumes load never coincides with a non-empty queue.
module ccm_outq
    import ccm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OUT_W-1:0]  data,
    input  logic              pop,
    output logic [BYTE_W-1:0] out_byte,
    output logic              vld,
    output logic              last
);
    logic [OUT_W-1:0] sreg;
    logic [CNT_W-1:0] cnt;

    // Hold the frame and count the bytes still to be taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= data;
            cnt  <= CNT_W'(OUT_B);
        end else if (pop && cnt != '0) begin
            sreg <= {sreg[OUT_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            cnt  <= cnt - 1'b1;
        end
    end

    // Expose the head byte and the queue status.
    always_comb begin
        out_byte = sreg[OUT_W-1 -: BYTE_W];
        vld      = (cnt != '0);
        last     = (cnt == CNT_W'(1));
    end
endmodule

// File: rtl/ccm_seq.sv
// CCM authenticated encryption sequencer around one external block cipher.
// A step index time-shares the engine: four MAC calls, then counter
// blocks 1 and 0. Assumes the engine answers each start with one done.
module ccm_seq
    import ccm_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_stb,
    input  logic [7:0]   key_byte,
    input  logic [7:0]   nonce_byte,
    input  logic [7:0]   aad_byte,
    input  logic [7:0]   pt_byte,
    input  logic         go,
    input  logic         pop,
    output logic [7:0]   out_byte,
    output logic         out_vld,
    output logic         eng_start,
    output logic [127:0] eng_key,
    output logic [127:0] eng_block,
    input  logic         eng_done,
    input  logic [127:0] eng_result
);
    state_e             state;
    step_e              step;
    logic [BLK_W-1:0]   chain;
    logic [BLK_W-1:0]   ct;
    logic [NONCE_W-1:0] nonce_q;
    logic [BLK_W-1:0]   aad_q;
    logic [BLK_W-1:0]   pt_q;
    logic               idle;
    logic               step_done;
    logic               q_load;
    logic               q_last;
    logic [OUT_W-1:0]   q_data;

    // Decode the control conditions shared by the processes below.
    always_comb begin
        idle      = (state == ST_IDLE);
        step_done = (state == ST_WAIT) && eng_done;
        q_load    = step_done && (step == STEP_CTR0);
        q_data    = {ct, chain[BLK_W-1 -: TAG_W] ^ eng_result[BLK_W-1 -: TAG_W]};
        eng_start = (state == ST_ISSUE);
    end

    ccm_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (ld_stb && idle),
        .key_byte   (key_byte),
        .nonce_byte (nonce_byte),
        .aad_byte   (aad_byte),
        .pt_byte    (pt_byte),
        .key_q      (eng_key),
        .nonce_q    (nonce_q),
        .aad_q      (aad_q),
        .pt_q       (pt_q)
    );

    ccm_blockmux u_mux (
        .step  (step),
        .chain (chain),
        .nonce (nonce_q),
        .aad   (aad_q),
        .pt    (pt_q),
        .blk   (eng_block)
    );

    ccm_outq u_outq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_load),
        .data     (q_data),
        .pop      (pop),
        .out_byte (out_byte),
        .vld      (out_vld),
        .last     (q_last)
    );

    // Job state machine with the loop-index step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= STEP_B0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    state <= ST_ISSUE;
                    step  <= STEP_B0;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (eng_done) begin
                    if (step == STEP_CTR0) begin
                        state <= ST_DRAIN;
                    end else begin
                        state <= ST_ISSUE;
                        step  <= step_e'(step + 3'd1);
                    end
                end
                default: if (pop && q_last) state <= ST_IDLE;
            endcase
        end
    end

    // Keep the MAC chain and the payload ciphertext from engine results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            ct    <= '0;
        end else if (step_done) begin
            if (step == STEP_CTR1) begin
                ct <= pt_q ^ eng_result;
            end else if (step != STEP_CTR0) begin
                chain <= eng_result;
            end
        end
    end
endmodule

// File: rtl/ccm_seq_chk.sv
// Protocol checker for the CCM sequencer ports, bound to every instance.
// Assumes the engine raises done once per start.
module ccm_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         eng_start,
    input logic         eng_done,
    input logic [127:0] eng_key,
    input logic         out_vld,
    input logic [7:0]   out_byte,
    input logic         pop
);
    logic pend;

    // Track whether an engine call is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (eng_start) pend <= 1'b1;
        else if (eng_done)  pend <= 1'b0;
    end

    // R7
    one_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !pend);
    // R11
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> $stable(eng_key));
    // R10
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !pop) |=> (out_vld && $stable(out_byte)));
    // R8
    out_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(eng_done));
    // R11
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !out_vld);
endmodule

bind ccm_seq ccm_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_key   (eng_key),
    .out_vld   (out_vld),
    .out_byte  (out_byte),
    .pop       (pop)
);

// File: tb/ccm_seq_bench.sv
// Self-checking bench: a stand-in keyed cipher with a programmable latency,
// and a reference CCM model computed here from the requirements.
module ccm_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_stb = 1'b0;
    logic [7:0]   key_byte = '0, nonce_byte = '0, aad_byte = '0, pt_byte = '0;
    logic         go = 1'b0;
    logic         pop = 1'b0;
    logic [7:0]   out_byte;
    logic         out_vld;
    logic         eng_start;
    logic [127:0] eng_key;
    logic [127:0] eng_block;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;

    int nchk = 0;
    int nfail = 0;
    int lat_cfg = 1;
    int ecnt = 0;
    int ncalls = 0;
    logic [127:0] ekey, eblk;
    logic [127:0] elog [256];
    logic [31:0]  seed = 32'h1234_5678;

    always #10 clk = ~clk;

    ccm_seq u_ccm_seq (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .key_byte(key_byte),
        .nonce_byte(nonce_byte), .aad_byte(aad_byte), .pt_byte(pt_byte),
        .go(go), .pop(pop), .out_byte(out_byte), .out_vld(out_vld),
        .eng_start(eng_start), .eng_key(eng_key), .eng_block(eng_block),
        .eng_done(eng_done), .eng_result(eng_result)
    );

    // Keyed nonlinear stand-in for the block cipher.
    function automatic logic [127:0] mix(input logic [127:0] k, input logic [127:0] x);
        logic [127:0] y;
        y = x ^ k;
        for (int r = 0; r < 4; r++) begin
            y = {y[100:0], y[127:101]} + (y ^ {k[63:0], k[127:64]});
            y = y ^ (y >> 19) ^ {120'd0, 8'(r * 37 + 1)};
        end
        return y;
    endfunction

    // Engine model, working on the falling edge to stay clear of the DUT edge.
    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) begin
            ecnt <= 0;
        end else if (eng_start) begin
            ekey <= eng_key;
            eblk <= eng_block;
            ecnt <= lat_cfg;
            elog[ncalls % 256] <= eng_block;
            ncalls <= ncalls + 1;
        end else if (ecnt == 1) begin
            eng_done   <= 1'b1;
            eng_result <= mix(ekey, eblk);
            ecnt       <= 0;
        end else if (ecnt > 1) begin
            ecnt <= ecnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            v = {v[95:0], seed};
        end
        return v;
    endfunction

    task automatic run_job(input int j, input int lat, input int stall, input bit disturb);
        logic [127:0] key, aad, pt, b0, a1, a2, c1, c0, x1, x2, x3, tmac, ct;
        logic [127:0] expb [6];
        logic [63:0]  nonce;
        logic [47:0]  tag;
        logic [175:0] frame;
        int base, waited;
        case (j % 4)
            0: begin key = '0; nonce = '0; aad = '0; pt = '0; end
            1: begin key = '1; nonce = '1; aad = '1; pt = '1; end
            2: begin
                for (int b = 0; b < 16; b++) begin
                    key[127-8*b -: 8] = 8'(8'h40 + b);
                    aad[127-8*b -: 8] = 8'(b);
                    pt[127-8*b -: 8]  = 8'(8'h20 + b);
                end
                nonce = 64'h1011_1213_1415_1617;
            end
            default: begin
                key = rnd128(); aad = rnd128(); pt = rnd128();
                nonce = rnd128()[63:0];
            end
        endcase
        lat_cfg = lat;
        // Load 16 beats; the nonce goes in the last eight (R2).
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            ld_stb = 1'b1;
            key_byte = key[127-8*b -: 8];
            aad_byte = aad[127-8*b -: 8];
            pt_byte  = pt[127-8*b -: 8];
            nonce_byte = (b >= 8) ? nonce[63-8*(b-8) -: 8] : 8'(8'hA5 ^ b);
        end
        @(negedge clk);
        ld_stb = 1'b0;
        chk(eng_key == key, "R2 key", eng_key, key);
        base = ncalls;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (disturb) begin
            // R11: junk loads, go and pop while the job runs.
            for (int b = 0; b < 16; b++) begin
                ld_stb = 1'b1; go = (b == 3); pop = (b == 5);
                key_byte = 8'hEE; nonce_byte = 8'h77; aad_byte = 8'h5A; pt_byte = 8'hC3;
                @(negedge clk);
            end
            ld_stb = 1'b0; go = 1'b0; pop = 1'b0;
            chk(eng_key == key, "R11 key kept", eng_key, key);
        end
        waited = 0;
        while (!out_vld && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk(out_vld, "R8 output ready", 128'(out_vld), 128'd1);
        // Reference model.
        b0 = {8'h56, nonce, 56'd16};
        a1 = {16'd16, aad[127:16]};
        a2 = {aad[15:0], 112'd0};
        c1 = {8'h06, nonce, 56'd1};
        c0 = {8'h06, nonce, 56'd0};
        x1 = mix(key, b0);
        x2 = mix(key, x1 ^ a1);
        x3 = mix(key, x2 ^ a2);
        tmac = mix(key, x3 ^ pt);
        ct = pt ^ mix(key, c1);
        tag = tmac[127:80] ^ mix(key, c0)[127:80];
        frame = {ct, tag};
        expb[0] = b0; expb[1] = x1 ^ a1; expb[2] = x2 ^ a2;
        expb[3] = x3 ^ pt; expb[4] = c1; expb[5] = c0;
        chk(ncalls - base == 6, "R7 call count", 128'(ncalls - base), 128'd6);
        chk(elog[base % 256][119:56] == nonce, "R2 nonce", elog[base % 256], b0);
        chk(elog[base % 256] == expb[0], "R3 B0", elog[base % 256], expb[0]);
        chk(elog[(base+1) % 256] == expb[1], "R4 first aad block", elog[(base+1) % 256], expb[1]);
        chk(elog[(base+2) % 256] == expb[2], "R4 second aad block", elog[(base+2) % 256], expb[2]);
        chk(elog[(base+3) % 256] == expb[3], "R5 payload block", elog[(base+3) % 256], expb[3]);
        chk(elog[(base+4) % 256] == expb[4], "R6 counter 1", elog[(base+4) % 256], expb[4]);
        chk(elog[(base+5) % 256] == expb[5], "R6 counter 0", elog[(base+5) % 256], expb[5]);
        // Drain 22 bytes with optional stalls.
        for (int i = 0; i < 22; i++) begin
            logic [7:0] e;
            e = frame[175-8*i -: 8];
            chk(out_vld && out_byte == e, (i < 16) ? "R8 ciphertext byte" : "R9 tag byte",
                128'({out_vld, out_byte}), 128'({1'b1, e}));
            if (stall != 0 && (i % 3) == stall - 1) begin
                @(negedge clk);
                chk(out_vld && out_byte == e, "R10 stalled byte",
                    128'({out_vld, out_byte}), 128'({1'b1, e}));
            end
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        chk(!out_vld, "R12 empty after last pop", 128'(out_vld), 128'd0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (5) @(negedge clk);
        chk(!out_vld && !eng_start, "R1 reset state", 128'({out_vld, eng_start}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_vld && !eng_start, "R1 after reset", 128'({out_vld, eng_start}), 128'd0);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        chk(!out_vld && !eng_start, "R10 idle pop ignored", 128'({out_vld, eng_start}), 128'd0);
        for (int j = 0; j < 12; j++) begin
            run_job(j, (j % 4 == 0) ? 1 : ((j * 5) % 23 + 1), j % 4, (j == 5 || j == 10));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule